// File: doc/BRIEF.md
# Stream Table Entry Walker

This block turns a stream identifier into the 64-byte stream table entry that describes that stream. It then reads the entry from memory over a read-only port that carries one 32-bit word per transfer. Configuration comes from static inputs: the table base address, the number of valid stream identifier bits, a two-level enable and a split width.

In linear mode the entry address follows directly from the base and the identifier. In two-level mode the walker first reads an 8-byte level-1 descriptor. It checks the span held in that descriptor and then reads the level-2 entry that the descriptor points to. A walk ends in one of two ways. It can end with a done pulse, with all sixteen entry words on the output. It can also end with a fault pulse that carries a fault code and an address. The walker does not decode the contents of the entry.

Top module: `strm_tbl_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `fault` are all low.
- R2: A stream identifier with any bit set at or above position `cfg_sid_bits` ends the walk with `fault` and `fault_code` = 1 (bad identifier), `fault_addr` = 0, and no memory read. An identifier of 2^`cfg_sid_bits` − 1 is accepted.
- R3: In linear mode (`cfg_two_lvl` = 0) the entry is read from `cfg_base` + identifier × 64 as 16 reads at ascending addresses 4 bytes apart. Word k of the entry appears on `ste_data[32k+31:32k]` when `done` pulses.
- R4: In two-level mode the level-1 descriptor is read as two words, the low word first. Its address is `cfg_base` with bits 5:0 cleared, plus (identifier >> `cfg_split`) × 8.
- R5: A level-1 descriptor whose span (low word bits 3:0) is zero ends the walk with `fault_code` = 1 and `fault_addr` = descriptor address, and no entry is read.
- R6: The level-2 index is the low `cfg_split` bits of the identifier. An index above 2^span − 1 ends the walk with `fault_code` = 2 (bad entry) and `fault_addr` = descriptor address. An index equal to 2^span − 1 is accepted.
- R7: In two-level mode the entry address is the level-2 pointer plus the level-2 index × 64. The pointer is the descriptor's high word above its low word, with the low word's bits 4:0 cleared.
- R8: A read that returns `mem_rerr` ends the walk at once with `fault_code` = 3 (fetch) and no further read. `fault_addr` is the start address of the structure being read: the descriptor or the entry.
- R9: `done` and `fault` are single-cycle pulses and never high together. `busy` is low in the cycle they are high. `start` is ignored while `busy` is high.
- R10: While `mem_req` is high and no response has arrived, `mem_req` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk for `sid` (taken only when idle) |
| sid | input | SID_W | Stream identifier |
| cfg_base | input | ADDR_W | Stream table base address |
| cfg_sid_bits | input | SB_W | Number of valid identifier bits |
| cfg_two_lvl | input | 1 | 1 selects the two-level table |
| cfg_split | input | SB_W | Identifier bits that index the level-2 table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request, held until a response |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Response for the held request |
| mem_rdata | input | 32 | Read data |
| mem_rerr | input | 1 | Read failed |
| done | output | 1 | Entry fetched (pulse) |
| ste_data | output | 512 | Sixteen entry words, word 0 in the low bits |
| fault | output | 1 | Walk failed (pulse) |
| fault_code | output | 2 | 1 bad identifier, 2 bad entry, 3 fetch error |
| fault_addr | output | ADDR_W | Address tied to the fault |

## Verification
The address computation is tried with linear walks and with two-level walks through a descriptor that has a nonzero pointer in both words. These walks separate a correct base mask, shift and pointer assembly from a wrong one, because every entry word is compared with a value derived from its own address. The level-2 index is driven to the last allowed value and to one past it, and a zero-span descriptor is read, so that the two fault codes are told apart and each is checked at its boundary. Read errors are injected on the second descriptor word and on a middle entry word. These cases show that the walk stops at once and reports the base of the structure, not the failing word. A second start during a walk shows that the first identifier alone decides the result.

// File: rtl/stw_pkg.sv
// Shared constants and types for the stream table walker.
// Assumes 32-bit memory words and 64-byte table entries.
package stw_pkg;
    localparam int STE_WORDS  = 16;
    localparam int WORD_W     = 32;
    localparam int ENTRY_SH   = 6;   // log2 of entry size in bytes
    localparam int DESC_SH    = 3;   // log2 of level-1 descriptor size
    localparam int PTR_LOW    = 5;   // pointer bits cleared in the low word

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_BAD_SID   = 2'd1,
        FLT_BAD_ENTRY = 2'd2,
        FLT_FETCH     = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_L1,
        ST_L2CHK,
        ST_ENTRY
    } walk_st_e;
endpackage

// File: rtl/stw_addr_gen.sv
// Address generator: derives every address and check result of a walk
// from the latched identifier, the configuration and the level-1 words.
// Purely combinational. Assumes 32 < ADDR_W <= 64.
module stw_addr_gen
    import stw_pkg::*;
#(
    parameter int SID_W  = 16,
    parameter int ADDR_W = 48,
    parameter int SB_W   = $clog2(SID_W + 1)
) (
    input  logic [SID_W-1:0]  sid,
    input  logic [ADDR_W-1:0] base,
    input  logic [SB_W-1:0]   sid_bits,
    input  logic [SB_W-1:0]   split,
    input  logic              two_lvl,
    input  logic [WORD_W-1:0] l1_w0,
    input  logic [WORD_W-1:0] l1_w1,
    output logic              sid_ok,
    output logic [ADDR_W-1:0] l1_addr,
    output logic              span_zero,
    output logic              span_over,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [SID_W-1:0]  l1_idx, l2_idx, l2_mask;
    logic [ADDR_W-1:0] base_al, l2_ptr, lin_addr, two_addr;
    logic [3:0]        span;
    logic              unused_bit4;

    // Range check and identifier split into level-1 and level-2 indices
    always_comb begin
        sid_ok  = ((sid >> sid_bits) == '0);
        l2_mask = ~({SID_W{1'b1}} << split);
        l1_idx  = sid >> split;
        l2_idx  = sid & l2_mask;
    end

    // Level-1 descriptor address from the entry-aligned base
    always_comb begin
        base_al = {base[ADDR_W-1:ENTRY_SH], {ENTRY_SH{1'b0}}};
        l1_addr = base_al + (ADDR_W'(l1_idx) << DESC_SH);
    end

    // Span checks on the fetched descriptor
    always_comb begin
        span      = l1_w0[3:0];
        span_zero = (span == 4'd0);
        span_over = ((l2_idx >> span) != '0);
    end

    // Entry address for either table layout
    always_comb begin
        l2_ptr     = ADDR_W'({l1_w1, l1_w0[WORD_W-1:PTR_LOW], {PTR_LOW{1'b0}}});
        lin_addr   = base + (ADDR_W'(sid) << ENTRY_SH);
        two_addr   = l2_ptr + (ADDR_W'(l2_idx) << ENTRY_SH);
        entry_addr = two_lvl ? two_addr : lin_addr;
    end

    assign unused_bit4 = l1_w0[4];
endmodule

// File: rtl/stw_ste_buf.sv
// Entry buffer: one register per entry word, written by beat index.
// Assumes at most one write per cycle; contents persist until overwritten.
module stw_ste_buf #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic [WORDS*DW-1:0] data_out
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        // Capture the beat addressed to this word
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                word_q <= wr_data;
        end
        assign data_out[g*DW +: DW] = word_q;
    end
endmodule

// File: rtl/stw_seq.sv
// Walk sequencer: controls the walk, issues one memory read at a time,
// holds each request until its response and reports done or a fault.
// Assumes the configuration is stable while busy.
module stw_seq
    import stw_pkg::*;
#(
    parameter int SID_W  = 16,
    parameter int ADDR_W = 48,
    localparam int BW    = $clog2(STE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SID_W-1:0]  sid_in,
    input  logic              two_lvl,
    input  logic              sid_ok,
    input  logic [ADDR_W-1:0] l1_addr,
    input  logic              span_zero,
    input  logic              span_over,
    input  logic [ADDR_W-1:0] entry_addr,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [SID_W-1:0]  sid_q,
    output logic [WORD_W-1:0] l1_w0,
    output logic [WORD_W-1:0] l1_w1,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              buf_we,
    output logic [BW-1:0]     buf_idx,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam logic [BW-1:0] LAST = BW'(STE_WORDS - 1);

    walk_st_e          state;
    logic [BW-1:0]     beat;
    logic [ADDR_W-1:0] cur_base, faddr_q;
    logic              done_q, fault_q;
    flt_e              code_q;
    logic              beat_ok, beat_err;

    // Handshake decode and request outputs
    always_comb begin
        beat_ok  = mem_rvalid && !mem_rerr;
        beat_err = mem_rvalid && mem_rerr;
        mem_req  = (state == ST_L1) || (state == ST_ENTRY);
        mem_addr = cur_base + (ADDR_W'(beat) << 2);
        busy     = (state != ST_IDLE);
        buf_we   = (state == ST_ENTRY) && beat_ok;
        buf_idx  = beat;
    end

    // Walk state machine with result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat     <= '0;
            cur_base <= '0;
            sid_q    <= '0;
            l1_w0    <= '0;
            l1_w1    <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            code_q   <= FLT_NONE;
            faddr_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sid_q <= sid_in;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    beat <= '0;
                    if (!sid_ok) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_BAD_SID;
                        faddr_q <= '0;
                        state   <= ST_IDLE;
                    end else if (two_lvl) begin
                        cur_base <= l1_addr;
                        state    <= ST_L1;
                    end else begin
                        cur_base <= entry_addr;
                        state    <= ST_ENTRY;
                    end
                end
                ST_L1: begin
                    if (beat_err) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_FETCH;
                        faddr_q <= cur_base;
                        state   <= ST_IDLE;
                    end else if (beat_ok) begin
                        if (beat == '0) begin
                            l1_w0 <= mem_rdata;
                            beat  <= BW'(1);
                        end else begin
                            l1_w1 <= mem_rdata;
                            state <= ST_L2CHK;
                        end
                    end
                end
                ST_L2CHK: begin
                    beat <= '0;
                    if (span_zero || span_over) begin
                        fault_q <= 1'b1;
                        code_q  <= span_zero ? FLT_BAD_SID : FLT_BAD_ENTRY;
                        faddr_q <= cur_base;
                        state   <= ST_IDLE;
                    end else begin
                        cur_base <= entry_addr;
                        state    <= ST_ENTRY;
                    end
                end
                ST_ENTRY: begin
                    if (beat_err) begin
                        fault_q <= 1'b1;
                        code_q  <= FLT_FETCH;
                        faddr_q <= cur_base;
                        state   <= ST_IDLE;
                    end else if (beat_ok) begin
                        if (beat == LAST) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            beat <= beat + BW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign fault      = fault_q;
    assign fault_code = code_q;
    assign fault_addr = faddr_q;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R10

    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R9

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !busy); // R9

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && mem_rerr) |=>
            (fault && fault_code == FLT_FETCH && !mem_req)); // R8

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTRY && beat_ok && beat != LAST) |=>
            (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4))); // R3
endmodule

// File: rtl/strm_tbl_walker.sv
// Stream table walker top: joins the address generator, the sequencer
// and the entry buffer. Assumes a memory port that answers each held
// request with exactly one response.
module strm_tbl_walker
    import stw_pkg::*;
#(
    parameter int SID_W   = 16,
    parameter int ADDR_W  = 48,
    localparam int SB_W   = $clog2(SID_W + 1),
    localparam int DATA_W = STE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SID_W-1:0]  sid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SB_W-1:0]   cfg_sid_bits,
    input  logic              cfg_two_lvl,
    input  logic [SB_W-1:0]   cfg_split,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              done,
    output logic [DATA_W-1:0] ste_data,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int BW = $clog2(STE_WORDS);

    logic [SID_W-1:0]  sid_q;
    logic [WORD_W-1:0] l1_w0, l1_w1;
    logic              sid_ok, span_zero, span_over, buf_we;
    logic [ADDR_W-1:0] l1_addr, entry_addr;
    logic [BW-1:0]     buf_idx;

    stw_addr_gen #(.SID_W(SID_W), .ADDR_W(ADDR_W), .SB_W(SB_W)) u_addr (
        .sid        (sid_q),
        .base       (cfg_base),
        .sid_bits   (cfg_sid_bits),
        .split      (cfg_split),
        .two_lvl    (cfg_two_lvl),
        .l1_w0      (l1_w0),
        .l1_w1      (l1_w1),
        .sid_ok     (sid_ok),
        .l1_addr    (l1_addr),
        .span_zero  (span_zero),
        .span_over  (span_over),
        .entry_addr (entry_addr)
    );

    stw_seq #(.SID_W(SID_W), .ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .sid_in     (sid),
        .two_lvl    (cfg_two_lvl),
        .sid_ok     (sid_ok),
        .l1_addr    (l1_addr),
        .span_zero  (span_zero),
        .span_over  (span_over),
        .entry_addr (entry_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .mem_rdata  (mem_rdata),
        .sid_q      (sid_q),
        .l1_w0      (l1_w0),
        .l1_w1      (l1_w1),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .done       (done),
        .fault      (fault),
        .fault_code (fault_code),
        .fault_addr (fault_addr)
    );

    stw_ste_buf #(.WORDS(STE_WORDS), .DW(WORD_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_idx   (buf_idx),
        .wr_data  (mem_rdata),
        .data_out (ste_data)
    );
endmodule

// File: tb/sim_strm_tbl_walker.sv
// Directed bench for the stream table walker; one task per scenario.
module sim_strm_tbl_walker;
    localparam int SID_W  = 16;
    localparam int ADDR_W = 48;
    localparam int SB_W   = $clog2(SID_W + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [SID_W-1:0]  sid = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [SB_W-1:0]   cfg_sid_bits = SB_W'(16);
    logic              cfg_two_lvl = 1'b0;
    logic [SB_W-1:0]   cfg_split = '0;
    logic              busy, mem_req, done, fault;
    logic [ADDR_W-1:0] mem_addr, fault_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              mem_rerr = 1'b0;
    logic [511:0]      ste_data;
    logic [1:0]        fault_code;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Memory model state
    logic [31:0]       l1mem [logic [47:0]];
    logic              err_en = 1'b0;
    logic [ADDR_W-1:0] err_addr = '0;
    logic [ADDR_W-1:0] beat_log [64];
    int                n_beats = 0;

    // Walk result capture
    logic              r_done, r_fault;
    logic [1:0]        r_code;
    logic [ADDR_W-1:0] r_faddr;

    strm_tbl_walker #(.SID_W(SID_W), .ADDR_W(ADDR_W)) u0 (
        .clk, .rst_n, .start, .sid, .cfg_base, .cfg_sid_bits, .cfg_two_lvl,
        .cfg_split, .busy, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .mem_rerr, .done, .ste_data, .fault, .fault_code, .fault_addr
    );

    always #2 clk = ~clk;  // 250 MHz

    function automatic logic [31:0] pat(input logic [ADDR_W-1:0] a);
        return a[31:0] ^ {a[47:32], 16'h3C3C};
    endfunction

    // Memory: one response per held request, one cycle after it is seen
    always @(posedge clk) begin
        if (mem_req && mem_rvalid) begin
            if (n_beats < 64) beat_log[n_beats] = mem_addr;
            n_beats = n_beats + 1;
        end
        if (mem_req && !mem_rvalid) begin
            mem_rvalid <= 1'b1;
            mem_rerr   <= err_en && (mem_addr == err_addr);
            mem_rdata  <= l1mem.exists(mem_addr) ? l1mem[mem_addr] : pat(mem_addr);
        end else begin
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Launch one walk and wait for its end; checks the pulse is one cycle (R9)
    task automatic walk(input logic [SID_W-1:0] s);
        int t;
        @(negedge clk);
        n_beats = 0;
        sid = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!(done || fault) && t < 500) begin
            @(negedge clk);
            t++;
        end
        r_done  = done;
        r_fault = fault;
        r_code  = fault_code;
        r_faddr = fault_addr;
        chk(!busy, "R9 busy low at end", 64'(busy), 64'd0);
        @(negedge clk);
        chk(!done && !fault, "R9 single-cycle end pulse", 64'({done, fault}), 64'd0);
    endtask

    task automatic chk_entry(input logic [ADDR_W-1:0] ea, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < 16; i++)
            if (ste_data[i*32 +: 32] != pat(ea + ADDR_W'(4 * i))) bad++;
        chk(bad == 0, tag, 64'(bad), 64'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !mem_req && !done && !fault, "R1 reset outputs",
            64'({busy, mem_req, done, fault}), 64'd0);
    endtask

    task automatic t_linear;
        logic [ADDR_W-1:0] ea;
        cfg_two_lvl = 1'b0; cfg_base = 48'h0000_1000; cfg_sid_bits = SB_W'(16);
        ea = 48'h0000_1000 + 48'd5 * 48'd64;
        walk(16'd5);
        chk(r_done && !r_fault, "R3 linear done", 64'({r_done, r_fault}), 64'h2);
        chk(beat_log[0] == ea, "R3 linear first address", 64'(beat_log[0]), 64'(ea));
        chk(n_beats == 16, "R3 linear beat count", 64'(n_beats), 64'd16);
        chk(beat_log[15] == ea + 48'd60, "R3 linear last address",
            64'(beat_log[15]), 64'(ea + 48'd60));
        chk_entry(ea, "R3 linear entry words");
    endtask

    task automatic t_sid_range;
        cfg_two_lvl = 1'b0; cfg_base = 48'h0000_1000; cfg_sid_bits = SB_W'(4);
        walk(16'd16);
        chk(r_fault && r_code == 2'd1, "R2 out-of-range identifier",
            64'({r_fault, r_code}), 64'h5);
        chk(r_faddr == '0 && n_beats == 0, "R2 no read, zero address",
            64'(n_beats), 64'd0);
        walk(16'd15);
        chk(r_done, "R2 largest identifier accepted", 64'(r_done), 64'd1);
        chk_entry(48'h0000_1000 + 48'd15 * 48'd64, "R2 edge identifier data");
        cfg_sid_bits = SB_W'(16);
    endtask

    task automatic t_two_level;
        logic [ADDR_W-1:0] ea;
        cfg_two_lvl = 1'b1; cfg_base = 48'h2000_0010; cfg_split = SB_W'(4);
        ea = 48'h0012_4000_1000 + 48'd5 * 48'd64;
        walk(16'h0035);
        chk(r_done, "R7 two-level done", 64'(r_done), 64'd1);
        chk(beat_log[0] == 48'h2000_0018, "R4 descriptor address",
            64'(beat_log[0]), 64'h2000_0018);
        chk(beat_log[1] == 48'h2000_001C, "R4 descriptor high word",
            64'(beat_log[1]), 64'h2000_001C);
        chk(beat_log[2] == ea, "R7 entry address", 64'(beat_log[2]), 64'(ea));
        chk(n_beats == 18, "R7 beat count", 64'(n_beats), 64'd18);
        chk_entry(ea, "R7 entry words");
    endtask

    task automatic t_span_bound;
        walk(16'h0037);
        chk(r_done, "R6 last allowed index", 64'(r_done), 64'd1);
        chk_entry(48'h0012_4000_1000 + 48'd7 * 48'd64, "R6 last index data");
        walk(16'h0038);
        chk(r_fault && r_code == 2'd2, "R6 index past span",
            64'({r_fault, r_code}), 64'h6);
        chk(r_faddr == 48'h2000_0018 && n_beats == 2, "R6 fault address",
            64'(r_faddr), 64'h2000_0018);
    endtask

    task automatic t_span_zero;
        walk(16'h0040);
        chk(r_fault && r_code == 2'd1, "R5 zero span", 64'({r_fault, r_code}), 64'h5);
        chk(r_faddr == 48'h2000_0020 && n_beats == 2, "R5 fault address",
            64'(r_faddr), 64'h2000_0020);
    endtask

    task automatic t_fetch_err;
        err_en = 1'b1; err_addr = 48'h2000_001C;
        walk(16'h0035);
        chk(r_fault && r_code == 2'd3, "R8 descriptor read error",
            64'({r_fault, r_code}), 64'h7);
        chk(r_faddr == 48'h2000_0018 && n_beats == 2, "R8 descriptor fault address",
            64'(r_faddr), 64'h2000_0018);
        cfg_two_lvl = 1'b0; cfg_base = 48'h0000_1000;
        err_addr = 48'h0000_1080 + 48'd28;
        walk(16'd2);
        chk(r_fault && r_code == 2'd3, "R8 entry read error",
            64'({r_fault, r_code}), 64'h7);
        chk(r_faddr == 48'h0000_1080, "R8 entry fault address",
            64'(r_faddr), 64'h1080);
        repeat (3) @(negedge clk);
        chk(n_beats == 8 && !mem_req, "R8 no read after error", 64'(n_beats), 64'd8);
        err_en = 1'b0;
    endtask

    task automatic t_busy_ignore;
        int t;
        cfg_two_lvl = 1'b0; cfg_base = 48'h0000_1000;
        @(negedge clk);
        n_beats = 0; sid = 16'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        sid = 16'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R9 first walk completes", 64'(done), 64'd1);
        chk_entry(48'h0000_1000 + 48'd64, "R9 start ignored while busy");
        repeat (4) @(negedge clk);
        chk(!busy && n_beats == 16, "R9 no second walk", 64'(n_beats), 64'd16);
    endtask

    initial begin
        l1mem[48'h2000_0018] = 32'h4000_1013;  // span 3, pointer low
        l1mem[48'h2000_001C] = 32'h0000_0012;  // pointer high
        l1mem[48'h2000_0020] = 32'h5000_0000;  // span 0
        l1mem[48'h2000_0024] = 32'h0000_0000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_linear();
        t_sid_range();
        t_two_level();
        t_span_bound();
        t_span_zero();
        t_fetch_err();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule